// File: doc/BRIEF.md
# Multi-Channel Variable-Resolution PWM DAC

This block drives a bank of pulse-width-modulated outputs that, after external RC filtering, set analog control levels such as volume, contrast or tuning voltages. All channels share one time base. A prescaler divides the internal clock by two, and a shared period counter runs from zero up to a wrap point that a resolution setting chooses. Each channel compares the counter against its own duty value and holds its output high while the counter is below that value.

Software writes duty values and the resolution setting through a small write port with a valid/ready handshake. A write lands in a shadow copy and moves into the active copy only when the period counter wraps, so a changed duty never cuts a pulse short or stretches it. A lower resolution shortens the period and raises the repetition rate. At 12 MHz, 8-bit mode gives 512 clocks per period (about 23.4 kHz) and 6-bit mode gives 128 clocks (about 94 kHz). Each output feeds an open-drain pad model. The pad is pulled low when the level is 0 and released when it is 1.

Top module: `pwm_dac_bank`

## Requirements
- R1: The period counter advances by one every PRESCALE (default 2) clocks. At the default setting, duty 1 in 8-bit mode gives a high level for exactly 2 clocks out of 512.
- R2: The resolution setting is written at address 8, bits [1:0]. Code 0 and code 3 select 8 bits (256 counts), code 1 selects 7 bits (128 counts) and code 2 selects 6 bits (64 counts). The counter wraps to 0 after the last count of the active mode.
- R3: A channel's level is 1 while the count is below its duty value shifted right by (8 minus the resolution). Reduced modes therefore use the upper bits of the duty value.
- R4: Duty 0 holds the level low for the whole period. Duty 255 leaves it low for exactly one count, which is 2 clocks in 8-bit mode.
- R5: A duty value written to address 0..7, or a resolution code, takes effect at the first counter wrap after the write. Until then the active values hold.
- R6: After reset, the counter is 0, all duties are 0, the mode is 8-bit and every level is low. The values written to the shadow copies also reset to 0 and 8-bit.
- R7: pad_out is always 0. pad_oe is 1 (drive low) when the level is 0, and 0 (pad released) when the level is 1.
- R8: wr_ready is low in reset and goes high one clock after reset is released. A write is accepted on a clock where wr_valid and wr_ready are both high. A write to any address from 9 to 15 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Write port able to accept |
| wr_addr | input | 4 | 0..7 duty per channel, 8 resolution code |
| wr_data | input | 8 | Write data |
| pwm_level | output | 8 | Logic level per channel |
| pad_out | output | 8 | Pad drive value (always 0) |
| pad_oe | output | 8 | Pad drive enable, 1 pulls the pad low |

## Verification
The hardest situation to reach from the ports is a write that arrives on the same clock as a counter wrap, or just before or after one. It decides whether the old or the new duty governs the next period. The stimulus issues writes at several fixed offsets while the counter runs freely, and issues resolution changes mid-period, so writes fall on and near period boundaries in every mode. A behavioural model that tracks prescaler phase, count, shadow values and active values checks every output on every clock.

// File: rtl/pwm_dac_pkg.sv
package pwm_dac_pkg;
  typedef enum logic [1:0] {
    RES_FULL = 2'd0,
    RES_LESS1 = 2'd1,
    RES_LESS2 = 2'd2,
    RES_FULL_ALT = 2'd3
  } res_sel_e;

  function automatic logic [1:0] res_shift(input res_sel_e r);
    case (r)
      RES_LESS1: res_shift = 2'd1;
      RES_LESS2: res_shift = 2'd2;
      default:   res_shift = 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_dac_pkg::*;
#(
  parameter int PRESCALE = 2,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  res_sel_e      mode_next,
  output logic [CW-1:0] cnt,
  output logic          tick,
  output logic          wrap,
  output logic [1:0]    shift,
  output logic [CW-1:0] limit
);
  res_sel_e mode_act;

  generate
    if (PRESCALE > 1) begin : g_pre
      localparam int PW = $clog2(PRESCALE);
      localparam logic [PW-1:0] PLAST = PW'(PRESCALE - 1);
      logic [PW-1:0] pre;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre <= '0;
        else if (pre == PLAST) pre <= '0;
        else pre <= pre + 1'b1;
      end
      assign tick = (pre == PLAST);
    end else begin : g_nopre
      assign tick = 1'b1;
    end
  endgenerate

  assign shift = res_shift(mode_act);
  assign limit = {CW{1'b1}} >> shift;
  assign wrap  = tick && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      mode_act <= RES_FULL;
    end else if (tick) begin
      if (cnt == limit) begin
        cnt      <= '0;
        mode_act <= mode_next;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwm_duty_regs.sv
module pwm_duty_regs
  import pwm_dac_pkg::*;
#(
  parameter int NCH = 8,
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [DW-1:0]           wr_data,
  input  logic                    wrap,
  output logic [NCH-1:0][DW-1:0]  act_duty,
  output res_sel_e                mode_shadow
);
  localparam logic [AW-1:0] CTRL_ADDR = AW'(NCH);

  logic [NCH-1:0][DW-1:0] shadow;

  genvar i;
  generate
    for (i = 0; i < NCH; i++) begin : g_ch
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          shadow[i]   <= '0;
          act_duty[i] <= '0;
        end else begin
          if (wrap) act_duty[i] <= shadow[i];
          if (wr_en && wr_addr == AW'(i)) shadow[i] <= wr_data;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_shadow <= RES_FULL;
    else if (wr_en && wr_addr == CTRL_ADDR) mode_shadow <= res_sel_e'(wr_data[1:0]);
  end
endmodule

// File: rtl/pwm_compare.sv
module pwm_compare #(
  parameter int NCH = 8,
  parameter int DW = 8
) (
  input  logic [DW-1:0]          cnt,
  input  logic [1:0]             shift,
  input  logic [NCH-1:0][DW-1:0] act_duty,
  output logic [NCH-1:0]         level
);
  genvar i;
  generate
    for (i = 0; i < NCH; i++) begin : g_cmp
      logic [DW-1:0] thr;
      assign thr      = act_duty[i] >> shift;
      assign level[i] = (cnt < thr);
    end
  endgenerate
endmodule

// File: rtl/pwm_dac_bank.sv
module pwm_dac_bank
  import pwm_dac_pkg::*;
#(
  parameter int NCH = 8,
  parameter int DW = 8,
  parameter int PRESCALE = 2,
  parameter int AW = $clog2(NCH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_valid,
  output logic           wr_ready,
  input  logic [AW-1:0]  wr_addr,
  input  logic [DW-1:0]  wr_data,
  output logic [NCH-1:0] pwm_level,
  output logic [NCH-1:0] pad_out,
  output logic [NCH-1:0] pad_oe
);
  logic [DW-1:0]          cnt;
  logic                   tick;
  logic                   wrap;
  logic [1:0]             shift;
  logic [DW-1:0]          limit;
  logic [NCH-1:0][DW-1:0] act_duty;
  res_sel_e               mode_shadow;
  logic                   ready_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else ready_q <= 1'b1;
  end
  assign wr_ready = ready_q;

  pwm_timebase #(.PRESCALE(PRESCALE), .CW(DW)) u_tb (
    .clk(clk), .rst_n(rst_n), .mode_next(mode_shadow),
    .cnt(cnt), .tick(tick), .wrap(wrap), .shift(shift), .limit(limit)
  );

  pwm_duty_regs #(.NCH(NCH), .DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_valid && ready_q),
    .wr_addr(wr_addr), .wr_data(wr_data), .wrap(wrap),
    .act_duty(act_duty), .mode_shadow(mode_shadow)
  );

  pwm_compare #(.NCH(NCH), .DW(DW)) u_cmp (
    .cnt(cnt), .shift(shift), .act_duty(act_duty), .level(pwm_level)
  );

  assign pad_out = '0;
  assign pad_oe  = ~pwm_level;
endmodule

// File: rtl/pwm_dac_bank_chk.sv
module pwm_dac_bank_chk #(
  parameter int NCH = 8,
  parameter int DW = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wr_ready,
  input logic [NCH-1:0]         pwm_level,
  input logic [NCH-1:0]         pad_out,
  input logic [NCH-1:0]         pad_oe,
  input logic [DW-1:0]          cnt,
  input logic                   tick,
  input logic                   wrap,
  input logic [DW-1:0]          limit,
  input logic [NCH-1:0][DW-1:0] act_duty
);
  p_hold_between_ticks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));
  p_wrap_to_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == '0));
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= limit);
  p_active_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(act_duty));
  p_reset_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pwm_level == '0));
  p_pad_polarity_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out == '0) && (pad_oe == ~pwm_level));
  p_ready_after_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> wr_ready);
endmodule

bind pwm_dac_bank pwm_dac_bank_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_ready(wr_ready), .pwm_level(pwm_level),
  .pad_out(pad_out), .pad_oe(pad_oe), .cnt(cnt), .tick(tick), .wrap(wrap),
  .limit(limit), .act_duty(act_duty)
);

// File: tb/pwm_dac_bank_test.sv
module pwm_dac_bank_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] pwm_level, pad_out, pad_oe;

  pwm_dac_bank uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .pwm_level(pwm_level),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  always #10 clk = ~clk;

  int vectors = 0, errors = 0, cyc = 0;
  bit done = 0;
  string phase = "R6";

  int m_c = 0, m_p = 0, m_rdy = 0, m_shres = 0, m_ares = 0;
  int m_sh[8] = '{default: 0};
  int m_act[8] = '{default: 0};

  function automatic int shf(int r);
    return (r == 1) ? 1 : (r == 2) ? 2 : 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_c = 0; m_p = 0; m_rdy = 0; m_shres = 0; m_ares = 0;
      foreach (m_sh[k]) begin m_sh[k] = 0; m_act[k] = 0; end
    end else begin
      if (m_p == 1) begin
        m_p = 0;
        if (m_c == (256 >> shf(m_ares)) - 1) begin
          m_c = 0;
          foreach (m_act[k]) m_act[k] = m_sh[k];
          m_ares = m_shres;
        end else m_c++;
      end else m_p++;
      if (wr_valid && m_rdy == 1) begin
        if (wr_addr < 8) m_sh[wr_addr] = wr_data;
        else if (wr_addr == 8) m_shres = wr_data & 3;
      end
      m_rdy = 1;
    end
  end

  function automatic logic [7:0] exp_level();
    logic [7:0] e;
    for (int k = 0; k < 8; k++) e[k] = (m_c < (m_act[k] >> shf(m_ares)));
    return e;
  endfunction

  always @(negedge clk) begin
    if (!done) begin
      logic [7:0] e;
      e = exp_level();
      vectors++;
      if (pwm_level !== e || wr_ready !== (m_rdy == 1)) begin
        errors++;
        $display("FAIL %s level/ready: got %h/%b expected %h/%0d", phase, pwm_level, wr_ready, e, m_rdy);
      end
      vectors++;
      if (pad_oe !== ~e || pad_out !== 8'h00) begin // R7
        errors++;
        $display("FAIL R7 pads: got oe=%h out=%h expected oe=%h out=00", pad_oe, pad_out, ~e);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      finish_run();
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a[3:0]; wr_data = d[7:0];
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_check(input string tag, input int ch, input bit lvl, input int want);
    int n = 0;
    for (int k = 0; k < 512; k++) begin
      @(negedge clk);
      if (pwm_level[ch] == lvl) n++;
    end
    vectors++;
    if (n != want) begin
      errors++;
      $display("FAIL %s ch%0d clocks at %b per period: got %0d expected %0d", tag, ch, lvl, n, want);
    end
  endtask

  initial begin
    // R6: reset state
    run(3);
    vectors++;
    if (pwm_level !== 8'h00 || wr_ready !== 1'b0) begin
      errors++;
      $display("FAIL R6 reset: got level=%h ready=%b expected 00/0", pwm_level, wr_ready);
    end
    rst_n = 1'b1;
    run(2);
    // R3, R4: assorted duties in 8-bit mode
    phase = "R3";
    wr(0, 0); wr(1, 255); wr(2, 128); wr(3, 1);
    wr(4, 64); wr(5, 200); wr(6, 3); wr(7, 254);
    run(1100);
    // R5: writes near and across boundaries
    phase = "R5";
    for (int k = 0; k < 6; k++) begin
      run(97 + k * 61);
      wr(2, 10 + k * 40);
      wr(k, 255 - k * 30);
    end
    run(600);
    // R2: resolution modes
    phase = "R2";
    wr(8, 1); run(700);
    wr(8, 2); wr(5, 17); run(400);
    wr(8, 3); run(600);
    // R8: unused addresses are ignored
    phase = "R8";
    for (int a = 9; a < 16; a++) wr(a, 8'hA5);
    run(1100);
    wr(8, 0); wr(1, 255); wr(0, 0); wr(3, 1); run(1100);
    // R4: exact low time at maximum and zero duty
    phase = "R4";
    count_check("R4", 1, 1'b0, 2);
    count_check("R4", 0, 1'b1, 0);
    // R1: prescale spacing
    phase = "R1";
    count_check("R1", 3, 1'b1, 2);
    finish_run();
  end
endmodule